// File: doc/BRIEF.md
# Paged EEPROM write-load sequencer

This block is the device-side write control for a byte-wide nonvolatile memory on an SRAM-style bus with active-low chip enable, output enable and write enable, a 17-bit address and 8-bit data. A write strobe occurs while chip enable and write enable are both low and output enable is high. Each such strobe loads one byte into a 128-byte page buffer. The first accepted byte opens a load window. Later bytes to the same page keep the window open as long as each arrives soon enough after the previous one. When the gap runs out, the block programs the loaded bytes into storage over a fixed number of cycles and then frees the bus for the next write.

All bus pins are sampled on the system clock. The inter-byte timeout and the programming time are parameters counted in clock cycles. Storage is a register array that holds `MEM_PAGES` pages. The page slot is taken from the low bits of the page field, so higher pages alias onto lower ones. Reads return stored contents. Status reporting during programming belongs to a separate block.

Top module: `eeprom_page_loader`

## Requirements
- R1: A byte is committed only by an overlap in which `ce_n`=0, `we_n`=0 and `oe_n`=1 hold together in the sampled pins. The commit happens on the first sample after the overlap in which that condition no longer holds. An overlap that never sees `oe_n`=1 commits nothing.
- R2: The address is taken from the first sample of the overlap, which is where the later of the two strobes fell. The data is taken from the last sample of the overlap, which is the value present before the earlier strobe rose.
- R3: A commit while idle makes `busy` go to 1 on the next clock edge and opens the load window.
- R4: During the load window, a commit to the same page is accepted if it falls within `LOAD_TO` cycles of the previous accepted commit. Offsets may arrive in any order, and a repeated offset keeps its latest data.
- R5: If `LOAD_TO` cycles pass with no accepted commit, programming starts. Programming lasts `PROG_CYC` cycles, and `busy` returns to 0 when it ends.
- R6: Only the offsets loaded in the window are written. Every other byte of the page keeps its stored value.
- R7: The page is address bits 16..7 and the offset is bits 6..0. A commit whose page differs from the window's page is dropped and sets `page_err`. `page_err` stays at 1 until reset.
- R8: Commits that occur during programming are ignored.
- R9: `dout` shows the stored byte at the addressed location (slot = page mod `MEM_PAGES`) while `ce_n`=0, `oe_n`=0 and `we_n`=1. Otherwise `dout` is 0. Bytes still in the buffer or being programmed do not appear until programming ends.
- R10: After reset, `busy`=0, `page_err`=0 and every stored byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address (page and offset) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| busy | output | 1 | Load window open or programming in progress |
| page_err | output | 1 | Sticky flag for a dropped off-page byte |

## Verification
Two situations are hard to reach from the pins. The first is a write strobe that lands while programming is running: the bench lets one window time out and then issues a new write at once, so its commit falls inside the programming period. The second is the capture points of a staggered strobe. Here chip enable falls first, the address changes when write enable falls, write enable rises first, and the data changes before chip enable rises. Only the later-fall address and the earlier-rise data may then reach storage.

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
  parameter int ADDR_W    = 17,
  parameter int OFF_W     = 7,
  parameter int MEM_PAGES = 16,
  parameter int LOAD_TO   = 30000,
  parameter int PROG_CYC  = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy,
  output logic              page_err
);
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int NBYTE  = 1 << OFF_W;
  localparam int SLOT_W = $clog2(MEM_PAGES);
  localparam int DEPTH  = MEM_PAGES * NBYTE;
  localparam int GW     = $clog2(LOAD_TO + 1);
  localparam int PW     = $clog2(PROG_CYC + 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(LOAD_TO - 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);

  typedef enum logic [1:0] {IDLE, LOAD, PROG} st_t;

  st_t               st;
  logic              s_ce, s_we, s_oe, act_q;
  logic [ADDR_W-1:0] s_addr, addr_l;
  logic [7:0]        s_din, din_l;
  logic [GW-1:0]     gap;
  logic [PW-1:0]     pcnt;
  logic [PG_W-1:0]   pg;
  logic [NBYTE-1:0]  mask;
  logic [7:0]        bufr [NBYTE];
  logic [7:0]        mem  [DEPTH];

  wire wr_act    = !s_ce && !s_we && s_oe;
  wire commit    = act_q && !wr_act;
  wire [OFF_W-1:0] off = addr_l[OFF_W-1:0];
  wire same_page = addr_l[ADDR_W-1:OFF_W] == pg;
  wire take      = commit && ((st == IDLE) || (st == LOAD && same_page));
  wire prog_done = (st == PROG) && (pcnt == PROG_LAST);

  assign busy = st != IDLE;
  assign dout = (!ce_n && !oe_n && we_n) ?
                mem[{addr[OFF_W+SLOT_W-1:OFF_W], addr[OFF_W-1:0]}] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_ce <= 1'b1; s_we <= 1'b1; s_oe <= 1'b1; act_q <= 1'b0;
      s_addr <= '0; s_din <= '0; addr_l <= '0; din_l <= '0;
    end else begin
      s_ce <= ce_n; s_we <= we_n; s_oe <= oe_n;
      s_addr <= addr; s_din <= din;
      act_q <= wr_act;
      if (wr_act && !act_q) addr_l <= s_addr;
      if (wr_act) din_l <= s_din;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; gap <= '0; pcnt <= '0; pg <= '0; page_err <= 1'b0;
    end else begin
      case (st)
        IDLE: if (commit) begin
          pg <= addr_l[ADDR_W-1:OFF_W];
          gap <= '0;
          st <= LOAD;
        end
        LOAD: begin
          if (commit && !same_page) page_err <= 1'b1;
          if (take) gap <= '0;
          else if (gap == GAP_LAST) begin
            st <= PROG;
            pcnt <= '0;
          end else gap <= gap + 1'b1;
        end
        default: if (prog_done) st <= IDLE;
                 else pcnt <= pcnt + 1'b1;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask <= '0;
    else if (prog_done) mask <= '0;
    else if (take) mask <= ((st == IDLE) ? '0 : mask) | (NBYTE'(1) << off);

  always_ff @(posedge clk)
    if (take) bufr[off] <= din_l;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (prog_done) begin
      for (int i = 0; i < NBYTE; i++)
        if (mask[i]) mem[{pg[SLOT_W-1:0], OFF_W'(i)}] <= bufr[i];
    end

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit) |=> busy);
  assert_gap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOAD) |-> (gap < GW'(LOAD_TO)));
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(prog_done));
  assert_idle_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mask == '0));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  assert_prog_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PROG && !prog_done) |=> ($stable(mask) && $stable(pg) && busy));
endmodule

// File: tb/tb_eeprom_page_loader.sv
module tb_eeprom_page_loader;
  localparam int AW = 17, LT = 40, PC = 25, NP = 4, DEPTH = NP * 128;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic busy, page_err;
  int checks = 0, errors = 0, cyc = 0;

  eeprom_page_loader #(.ADDR_W(AW), .OFF_W(7), .MEM_PAGES(NP), .LOAD_TO(LT), .PROG_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .page_err(page_err));

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit ms_ce = 1, ms_we = 1, ms_oe = 1, m_act = 0, m_err = 0;
  int ms_addr = 0, ms_din = 0, m_al = 0, m_dl = 0, m_st = 0, m_gap = 0, m_pc = 0, m_pg = 0;
  int m_buf [128];
  bit m_mask [128];
  int m_mem [DEPTH];

  function automatic int slot(int a);
    return ((a >> 7) % NP) * 128 + (a & 127);
  endfunction

  always @(posedge clk) begin
    bit act, cm;
    cyc++;
    if (!rst_n) begin
      ms_ce = 1; ms_we = 1; ms_oe = 1; m_act = 0; m_err = 0; m_st = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
      foreach (m_mask[i]) m_mask[i] = 0;
    end else begin
      act = !ms_ce && !ms_we && ms_oe;
      cm = m_act && !act;
      if (m_st == 0) begin
        if (cm) begin
          m_pg = m_al >> 7; m_buf[m_al & 127] = m_dl; m_mask[m_al & 127] = 1;
          m_gap = 0; m_st = 1;
        end
      end else if (m_st == 1) begin
        if (cm && (m_al >> 7) != m_pg) m_err = 1;
        if (cm && (m_al >> 7) == m_pg) begin
          m_buf[m_al & 127] = m_dl; m_mask[m_al & 127] = 1; m_gap = 0;
        end else if (m_gap == LT - 1) begin
          m_st = 2; m_pc = 0;
        end else m_gap++;
      end else begin
        if (m_pc == PC - 1) begin
          for (int i = 0; i < 128; i++)
            if (m_mask[i]) begin
              m_mem[(m_pg % NP) * 128 + i] = m_buf[i];
              m_mask[i] = 0;
            end
          m_st = 0;
        end else m_pc++;
      end
      if (act && !m_act) m_al = ms_addr;
      if (act) m_dl = ms_din;
      m_act = act;
      ms_ce = ce_n; ms_we = we_n; ms_oe = oe_n; ms_addr = int'(addr); ms_din = int'(din);
    end
    #1;
    if (rst_n) begin
      chk("R5 busy", busy, m_st != 0);
      chk("R7 page_err", page_err, m_err);
      chk("R9 dout", dout, (!ce_n && !oe_n && we_n) ? m_mem[slot(int'(addr))] : 0);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_we(int a, int d);
    @(negedge clk) addr = AW'(a); din = 8'(d); ce_n = 0; oe_n = 1;
    @(negedge clk) we_n = 0;
    repeat (2) @(negedge clk);
    @(negedge clk) we_n = 1;
    @(negedge clk) ce_n = 1;
  endtask

  task automatic wr_ce(int a, int d);
    @(negedge clk) addr = AW'(a); din = 8'(d); we_n = 0; oe_n = 1;
    @(negedge clk) ce_n = 0;
    repeat (2) @(negedge clk);
    @(negedge clk) ce_n = 1;
    @(negedge clk) we_n = 1;
  endtask

  task automatic rd(string tag, int a, int exp);
    @(negedge clk) addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1;
    #1 chk(tag, dout, exp);
    @(negedge clk) ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R10 busy reset", busy, 0);
    chk("R10 err reset", page_err, 0);
    rst_n = 1;
    rd("R10 mem zero", 200, 0);

    wr_we(133, 8'h11); wr_we(131, 8'h22); wr_we(133, 8'h33);
    wait_idle;
    rd("R4 latest value", 133, 8'h33);
    rd("R4 any order", 131, 8'h22);
    rd("R6 untouched", 132, 0);

    wr_ce(256, 8'hA5);
    repeat (2) @(negedge clk);
    #1 chk("R3 busy after first byte", busy, 1);
    rd("R9 not yet programmed", 256, 0);
    wait_idle;
    rd("R1 ce-controlled write", 256, 8'hA5);

    @(negedge clk) addr = AW'(300); din = 8'h01; ce_n = 0; oe_n = 1;
    @(negedge clk) addr = AW'(270); we_n = 0;
    @(negedge clk) din = 8'h5A;
    @(negedge clk) ;
    @(negedge clk) we_n = 1;
    @(negedge clk) din = 8'hC3; addr = AW'(300);
    @(negedge clk) ce_n = 1;
    wait_idle;
    rd("R2 later-fall address, early-rise data", 270, 8'h5A);
    rd("R2 earlier address not written", 300, 0);

    @(negedge clk) addr = AW'(257); din = 8'h99; ce_n = 0; oe_n = 0;
    @(negedge clk) we_n = 0;
    repeat (2) @(negedge clk);
    @(negedge clk) we_n = 1;
    @(negedge clk) ce_n = 1; oe_n = 1;
    repeat (4) @(negedge clk);
    #1 chk("R1 no commit with oe low", busy, 0);
    rd("R1 no write with oe low", 257, 0);

    wr_we(138, 8'h44); wr_we(394, 8'h55);
    repeat (2) @(negedge clk);
    #1 chk("R7 err raised", page_err, 1);
    wait_idle;
    rd("R7 off-page dropped", 394, 0);
    rd("R7 first page kept", 138, 8'h44);
    #1 chk("R7 err sticky", page_err, 1);

    wr_we(20, 8'h66);
    repeat (LT + 5) @(negedge clk);
    #1 chk("R5 programming busy", busy, 1);
    wr_we(21, 8'h77);
    wait_idle;
    rd("R5 timed-out byte programmed", 20, 8'h66);
    rd("R8 write during programming ignored", 21, 0);

    wr_we(40, 8'h12);
    repeat (LT - 15) @(negedge clk);
    wr_we(41, 8'h34);
    wait_idle;
    rd("R4 within gap first", 40, 8'h12);
    rd("R4 within gap second", 41, 8'h34);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule